// File: doc/BRIEF.md
# MDIO Management Slave with PHY Register Set

This block is the management-side slave of a transceiver: it watches a two-wire serial management bus (a clock, MDC, and a bidirectional data line, MDIO) and answers clause-22 style frames aimed at its own 5-bit address. The MDC and MDIO inputs are brought into the system clock domain through synchronisers. The block takes an input bit on each MDC rising edge and changes what it drives only after an MDC falling edge. Once a frame has been decoded, its 16 data bits either land in a 32-entry, 16-bit register array or are shifted back out most significant bit first.

Three addresses do not return what is stored in them. The status word (index 1) always reports full ability, link up and negotiation complete. The partner-ability word (index 5) echoes the advertised modes, so the far end always agrees with whatever is advertised. The diagnostic word (index 18) reports the speed and duplex that the advertisement resolves to. The stored array is also brought out flat on a wide port, so that neighbouring logic can use the programmed values directly.

Top module: `mdio_phy_slave`

## Requirements
- R1: After reset the array holds 0x3100 at index 0, 0x0300 at index 2, 0xE400 at index 3, 0x01E1 at index 4 and zero elsewhere. `regs_o[i*16 +: 16]` carries index i.
- R2: A frame is recognised only after at least 32 consecutive one bits, followed by a 0 and then a 1. With 31 or fewer ones, the frame that follows is ignored. Any run of 32 or more ones is accepted.
- R3: After the start bits, the frame carries 2 opcode bits, a 5-bit PHY address, a 5-bit register address, 2 turnaround bits and 16 data bits, each field MSB first. Opcode 2'b01 with a matching PHY address stores the data bits in the addressed entry.
- R4: For opcode 2'b10 with a matching address, the slave behaves as follows. `mdio_oe` stays low in the first turnaround bit. In the second turnaround bit the slave drives 0. It then drives the 16 read bits MSB first, and releases `mdio_oe` in the bit after the last data bit.
- R5: A frame whose PHY address differs from `phy_addr` neither writes the array nor drives `mdio_oe`.
- R6: A read of index 1 returns 0x782C, which has bits 14, 13, 12, 11, 5, 3 and 2 set.
- R7: A read of index 5 returns 0x4000 OR'd with bits [8:5] of index 4.
- R8: A read of index 18 returns bit 10 set when index 4 has bit 7 or bit 8 set, and bit 11 set when index 4 has bit 8 or bit 6 set. All other bits of this read are zero.
- R9: A read of any other index returns its stored contents.
- R10: `mdio_oe` stays low throughout write frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples MDC |
| rst | input | 1 | Synchronous active-high reset |
| mdc_i | input | 1 | Management clock from the bus master |
| mdio_i | input | 1 | Management data line as seen at the pad |
| phy_addr | input | 5 | Address this slave answers to |
| mdio_o | output | 1 | Data driven onto the line while enabled |
| mdio_oe | output | 1 | Output enable for the data line |
| regs_o | output | 512 | Flat copy of the stored 32 x 16 array |

## Verification
The bench uses the default parameters: 16-bit words, 32 entries, 5-bit address fields and a 32-bit minimum preamble. With these values index 18 exists, so all three computed reads can be reached. They also make the preamble threshold exact, which allows runs of 31, 32 and 40 ones to be compared. MDC runs at sixteen system clocks per bit, which leaves room for the synchroniser delay before each driven bit is sampled. The slave answers to address 0x0B, and frames sent to 0x0C exercise the address filter.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [2:0] {
    ST_PRE,
    ST_SOF,
    ST_OP,
    ST_PHY,
    ST_REG,
    ST_TA,
    ST_DATA
  } mdio_state_t;

  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  localparam int IDX_CTRL   = 0;
  localparam int IDX_STAT   = 1;
  localparam int IDX_ID_HI  = 2;
  localparam int IDX_ID_LO  = 3;
  localparam int IDX_ADV    = 4;
  localparam int IDX_LPA    = 5;
  localparam int IDX_DIAG   = 18;

  localparam logic [15:0] STAT_WORD = 16'h782C;
  localparam logic [15:0] LPA_ACK   = 16'h4000;
  localparam logic [15:0] ADV_MODES = 16'h01E0;

  function automatic logic [15:0] reset_word(input int idx);
    case (idx)
      IDX_CTRL:  return 16'h3100;
      IDX_ID_HI: return 16'h0300;
      IDX_ID_LO: return 16'hE400;
      IDX_ADV:   return 16'h01E1;
      default:   return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic mdc_i,
  input  logic mdio_i,
  output logic rise_o,
  output logic fall_o,
  output logic bit_o
);
  logic [2:0] mdc_s;
  logic [1:0] dio_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_s <= '0;
      dio_s <= '0;
    end else begin
      mdc_s <= {mdc_s[1:0], mdc_i};
      dio_s <= {dio_s[0], mdio_i};
    end
  end

  assign rise_o = mdc_s[1] & ~mdc_s[2];
  assign fall_o = ~mdc_s[1] & mdc_s[2];
  assign bit_o  = dio_s[1];
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 5,
  parameter int PRE_MIN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  input  logic              fall,
  input  logic              bit_in,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int PCW = $clog2(PRE_MIN + 1);
  localparam int CW  = $clog2(DATA_W) > $clog2(ADDR_W) ? $clog2(DATA_W) : $clog2(ADDR_W);
  localparam logic [PCW-1:0] PRE_TOP  = PRE_MIN[PCW-1:0];
  localparam logic [CW-1:0]  ADDR_END = CW'(ADDR_W - 1);
  localparam logic [CW-1:0]  DATA_END = CW'(DATA_W - 1);

  mdio_state_t       state;
  logic [PCW-1:0]    pre_cnt;
  logic [CW-1:0]     cnt;
  logic [1:0]        op;
  logic [ADDR_W-1:0] pa;
  logic [ADDR_W-1:0] ra;
  logic [DATA_W-1:0] rx_sh;
  logic [DATA_W-1:0] tx_sh;
  logic              is_rd;
  logic              is_wr;

  assign rd_addr = ra;
  assign wr_addr = ra;
  assign wr_data = {rx_sh[DATA_W-2:0], bit_in};
  assign wr_en   = rise && state == ST_DATA && cnt == DATA_END && is_wr;

  // Receive side: all sampling happens on MDC rising edges.
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_PRE;
      pre_cnt <= '0;
      cnt     <= '0;
      op      <= '0;
      pa      <= '0;
      ra      <= '0;
      rx_sh   <= '0;
      is_rd   <= 1'b0;
      is_wr   <= 1'b0;
    end else if (rise) begin
      case (state)
        ST_PRE: begin
          if (bit_in) begin
            if (pre_cnt != PRE_TOP) pre_cnt <= pre_cnt + 1'b1;
          end else begin
            if (pre_cnt == PRE_TOP) state <= ST_SOF;
            pre_cnt <= '0;
          end
        end
        ST_SOF: begin
          cnt   <= '0;
          state <= bit_in ? ST_OP : ST_PRE;
        end
        ST_OP: begin
          op <= {op[0], bit_in};
          if (cnt == CW'(1)) begin
            cnt   <= '0;
            state <= ST_PHY;
          end else cnt <= cnt + 1'b1;
        end
        ST_PHY: begin
          pa <= {pa[ADDR_W-2:0], bit_in};
          if (cnt == ADDR_END) begin
            cnt   <= '0;
            state <= ST_REG;
          end else cnt <= cnt + 1'b1;
        end
        ST_REG: begin
          ra <= {ra[ADDR_W-2:0], bit_in};
          if (cnt == ADDR_END) begin
            cnt   <= '0;
            state <= ST_TA;
            is_rd <= (op == OP_RD) && (pa == phy_addr);
            is_wr <= (op == OP_WR) && (pa == phy_addr);
          end else cnt <= cnt + 1'b1;
        end
        ST_TA: begin
          if (cnt == CW'(1)) begin
            cnt   <= '0;
            state <= ST_DATA;
          end else cnt <= cnt + 1'b1;
        end
        ST_DATA: begin
          rx_sh <= wr_data;
          if (cnt == DATA_END) begin
            cnt     <= '0;
            pre_cnt <= '0;
            state   <= ST_PRE;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= ST_PRE;
      endcase
    end
  end

  // Transmit side: the driven value changes only after MDC falling edges.
  always_ff @(posedge clk) begin
    if (rst) begin
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      tx_sh   <= '0;
    end else if (fall) begin
      if (state == ST_TA && cnt == CW'(1) && is_rd) begin
        mdio_oe <= 1'b1;
        mdio_o  <= 1'b0;
        tx_sh   <= rd_data;
      end else if (state == ST_DATA && is_rd) begin
        mdio_oe <= 1'b1;
        mdio_o  <= tx_sh[DATA_W-1];
        tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
      end else begin
        mdio_oe <= 1'b0;
        mdio_o  <= 1'b0;
      end
    end
  end

  // R2
  short_pre_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PRE && rise && !bit_in && pre_cnt < PRE_TOP) |=> (state == ST_PRE));

  // R4
  ta_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> !mdio_o);

  // R5
  drive_match_chk: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> is_rd);

  // R10
  write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA && is_wr) |-> !mdio_oe);
endmodule

// File: rtl/mdio_reg_file.sv
module mdio_reg_file
  import mdio_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 32,
  parameter int ADDR_W   = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  logic [DATA_W-1:0] mem [NUM_REGS];
  logic [DATA_W-1:0] adv;
  logic [DATA_W-1:0] lpa_word;
  logic [DATA_W-1:0] diag_word;
  logic              spd_100;
  logic              dup_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= DATA_W'(reset_word(i));
    end else if (wr_en && int'(wr_addr) < NUM_REGS) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign adv       = mem[IDX_ADV];
  assign spd_100   = adv[7] | adv[8];
  assign dup_full  = adv[8] | adv[6];
  assign lpa_word  = DATA_W'(LPA_ACK) | (adv & DATA_W'(ADV_MODES));
  assign diag_word = DATA_W'({dup_full, spd_100}) << 10;

  always_comb begin
    if (int'(rd_addr) == IDX_STAT)      rd_data = DATA_W'(STAT_WORD);
    else if (int'(rd_addr) == IDX_LPA)  rd_data = lpa_word;
    else if (int'(rd_addr) == IDX_DIAG) rd_data = diag_word;
    else if (int'(rd_addr) < NUM_REGS)  rd_data = mem[rd_addr];
    else                                rd_data = '0;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_o[g*DATA_W +: DATA_W] = mem[g];
  end

  // R1
  reset_val_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mem[IDX_CTRL] == 16'h3100 && mem[IDX_ADV] == 16'h01E1));

  // R3
  write_store_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/mdio_phy_slave.sv
module mdio_phy_slave #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 32,
  parameter int ADDR_W   = 5,
  parameter int PRE_MIN  = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       mdc_i,
  input  logic                       mdio_i,
  input  logic [ADDR_W-1:0]          phy_addr,
  output logic                       mdio_o,
  output logic                       mdio_oe,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  logic              rise;
  logic              fall;
  logic              bit_s;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;

  mdio_edge_sync u_sync (
    .clk    (clk),
    .rst    (rst),
    .mdc_i  (mdc_i),
    .mdio_i (mdio_i),
    .rise_o (rise),
    .fall_o (fall),
    .bit_o  (bit_s)
  );

  mdio_frame_fsm #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .PRE_MIN (PRE_MIN)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .rise     (rise),
    .fall     (fall),
    .bit_in   (bit_s),
    .phy_addr (phy_addr),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
  );

  mdio_reg_file #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .regs_o  (regs_o)
  );
endmodule

// File: tb/sim_mdio_phy_slave.sv
module sim_mdio_phy_slave;
  localparam int HALF = 8;
  localparam logic [4:0] MY_ADDR = 5'h0B;
  localparam logic [4:0] OTHER   = 5'h0C;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mdc_i = 1'b0;
  logic         mdio_i = 1'b1;
  logic [4:0]   phy_addr = MY_ADDR;
  logic         mdio_o;
  logic         mdio_oe;
  logic [511:0] regs_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  mdio_phy_slave u0 (
    .clk      (clk),
    .rst      (rst),
    .mdc_i    (mdc_i),
    .mdio_i   (mdio_i),
    .phy_addr (phy_addr),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .regs_o   (regs_o)
  );

  logic s_o, s_oe;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    mdc_i  = 1'b0;
    mdio_i = b;
    repeat (HALF) @(negedge clk);
    s_o  = mdio_o;
    s_oe = mdio_oe;
    mdc_i = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send_head(input int npre, input logic [1:0] op,
                           input logic [4:0] pa, input logic [4:0] ra);
    for (int i = 0; i < npre; i++) send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    for (int i = 1; i >= 0; i--) send_bit(op[i]);
    for (int i = 4; i >= 0; i--) send_bit(pa[i]);
    for (int i = 4; i >= 0; i--) send_bit(ra[i]);
  endtask

  task automatic do_write(input int npre, input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] d, output logic any_oe);
    any_oe = 1'b0;
    send_head(npre, 2'b01, pa, ra);
    send_bit(1'b1); any_oe |= s_oe;
    send_bit(1'b0); any_oe |= s_oe;
    for (int i = 15; i >= 0; i--) begin
      send_bit(d[i]);
      any_oe |= s_oe;
    end
    send_bit(1'b1); any_oe |= s_oe;
  endtask

  // shape_ok: oe low in TA1, oe high with 0 in TA2, oe high in all data bits, released after.
  task automatic do_read(input logic [4:0] pa, input logic [4:0] ra,
                         output logic [15:0] d, output logic shape_ok, output logic any_oe);
    send_head(32, 2'b10, pa, ra);
    send_bit(1'b1);
    shape_ok = !s_oe;
    any_oe = s_oe;
    send_bit(1'b1);
    shape_ok &= s_oe && !s_o;
    any_oe |= s_oe;
    for (int i = 15; i >= 0; i--) begin
      send_bit(1'b1);
      d[i] = s_o;
      shape_ok &= s_oe;
      any_oe |= s_oe;
    end
    send_bit(1'b1);
    shape_ok &= !s_oe;
    any_oe |= s_oe;
  endtask

  function automatic logic [15:0] reg_at(input int i);
    return regs_o[i*16 +: 16];
  endfunction

  task automatic t_reset();
    logic [15:0] d; logic ok, oe;
    check("R1 idx0", reg_at(0), 16'h3100);
    check("R1 idx2", reg_at(2), 16'h0300);
    check("R1 idx3", reg_at(3), 16'hE400);
    check("R1 idx4", reg_at(4), 16'h01E1);
    check("R1 idx9", reg_at(9), 16'h0000);
    check("R1 oe idle", {15'd0, mdio_oe}, 16'h0000);
    do_read(MY_ADDR, 5'd0, d, ok, oe);
    check("R9 read idx0", d, 16'h3100);
    check("R4 read shape", {15'd0, ok}, 16'h0001);
    do_read(MY_ADDR, 5'd3, d, ok, oe);
    check("R9 read idx3", d, 16'hE400);
  endtask

  task automatic t_status();
    logic [15:0] d; logic ok, oe;
    do_read(MY_ADDR, 5'd1, d, ok, oe);
    check("R6 status", d, 16'h782C);
    do_read(MY_ADDR, 5'd5, d, ok, oe);
    check("R7 partner reset", d, 16'h41E0);
    do_read(MY_ADDR, 5'd18, d, ok, oe);
    check("R8 diag reset", d, 16'h0C00);
  endtask

  task automatic t_write();
    logic [15:0] d; logic ok, oe;
    do_write(32, MY_ADDR, 5'd9, 16'hA5C3, oe);
    check("R3 stored idx9", reg_at(9), 16'hA5C3);
    check("R10 oe in write", {15'd0, oe}, 16'h0000);
    do_read(MY_ADDR, 5'd9, d, ok, oe);
    check("R9 read idx9", d, 16'hA5C3);
    check("R4 read shape idx9", {15'd0, ok}, 16'h0001);
  endtask

  task automatic t_adv();
    logic [15:0] d; logic ok, oe;
    do_write(32, MY_ADDR, 5'd4, 16'h0041, oe);
    check("R3 adv stored", reg_at(4), 16'h0041);
    do_read(MY_ADDR, 5'd5, d, ok, oe);
    check("R7 partner 10full", d, 16'h4040);
    do_read(MY_ADDR, 5'd18, d, ok, oe);
    check("R8 diag 10full", d, 16'h0800);
    do_write(32, MY_ADDR, 5'd4, 16'h0081, oe);
    do_read(MY_ADDR, 5'd5, d, ok, oe);
    check("R7 partner 100half", d, 16'h4080);
    do_read(MY_ADDR, 5'd18, d, ok, oe);
    check("R8 diag 100half", d, 16'h0400);
    do_write(32, MY_ADDR, 5'd4, 16'h0021, oe);
    do_read(MY_ADDR, 5'd18, d, ok, oe);
    check("R8 diag 10half", d, 16'h0000);
  endtask

  task automatic t_addr();
    logic [15:0] d; logic ok, oe;
    do_write(32, OTHER, 5'd9, 16'h1234, oe);
    check("R5 foreign write", reg_at(9), 16'hA5C3);
    do_read(OTHER, 5'd0, d, ok, oe);
    check("R5 foreign read oe", {15'd0, oe}, 16'h0000);
  endtask

  task automatic t_preamble();
    logic oe;
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    do_write(31, MY_ADDR, 5'd10, 16'h5555, oe);
    check("R2 short preamble", reg_at(10), 16'h0000);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    do_write(40, MY_ADDR, 5'd10, 16'h0F0F, oe);
    check("R2 long preamble", reg_at(10), 16'h0F0F);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_status();
    t_write();
    t_adv();
    t_addr();
    t_preamble();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule